// File: doc/BRIEF.md
# Transmit Descriptor and Status Queue Manager

This block runs the transmit side of a DMA network controller. Software places descriptors in a ring in memory and reports how many it added by writing a count to the enqueue port. The block keeps a pending count. While that count is non-zero and transmit DMA is on, it reads the descriptor at its descriptor pointer. It decodes the buffer address, the length, the last-buffer mark, the buffer index and the abort flag. It then hands the buffer to a frame sender once the sender says it is ready.

When the sender reports the outcome, the block packs a one-word status entry. That entry carries the outcome flags, the collision count and an echo of the descriptor's buffer index. The block writes it to the status ring at the status pointer, decrements the pending count and raises the transmit interrupt flag. A descriptor marked as aborted is never sent. It gets an aborted status straight away. Both pointers wrap after the last ring entry.

Descriptor reads have one cycle of latency. A read strobe at one clock edge returns data that is valid after the next edge.

Top module: `txq_manager`

## Requirements
- R1: After a synchronous reset, the pending count is 0. Both ring pointers start at entry 0, so the first fetch and the first status write use entry 0. No read, send or status-write strobe is active, and both the raw interrupt flag and the interrupt output are 0.
- R2: An enqueue strobe adds its count to the pending count in the next cycle. The pending count saturates at the ring depth (8) and never goes beyond it.
- R3: Descriptors are fetched only while the pending count is non-zero. They are fetched in ring order from entry 0, and the descriptor pointer wraps from entry 7 back to entry 0.
- R4: Descriptor decoding works as follows. Word 0 is the buffer address. In word 1, bit 31 marks the last buffer, bits 30:16 are the buffer index, bit 15 is the abort flag and bits 11:0 are the length. The address, the length and the last mark are presented to the sender with a one-cycle start pulse.
- R5: The status word always has bit 31 (processed) set. The other fields are:
  - bit 30: sent without error
  - bit 29: aborted
  - bit 28: carrier lost
  - bit 26: late collision
  - bit 25: underrun
  - bit 24: excessive collisions
  - bits 20:16: collision count
  - bits 14:0: echo of the descriptor's buffer index

  All other bits are 0.
- R6: A descriptor with the abort flag set produces no start pulse. Its status has bits 31 and 29 set, and bits 30, 28:16 are clear, with the index echoed.
- R7: Exactly one status word is written per descriptor, at the status pointer, in ring order with wrap from 7 to 0. Each write decrements the pending count.
- R8: Each status write sets the raw interrupt flag, and a clear strobe resets it. The interrupt output, a register, is the flag masked by the enable input, one cycle later.
- R9: While transmit DMA is disabled, no descriptor is read and the pending count holds its value. Enabling DMA drains the queue.
- R10: While the sender is not ready, no start pulse is issued. The send goes out once the sender becomes ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_en | input | 1 | Transmit DMA enable |
| enq_valid | input | 1 | Enqueue strobe |
| enq_count | input | ENQ_W | Number of descriptors added |
| desc_rd_en | output | 1 | Descriptor read strobe |
| desc_rd_addr | output | $clog2(DEPTH) | Ring entry being read |
| desc_word0 | input | 32 | Read data, buffer address |
| desc_word1 | input | 32 | Read data, control word |
| snd_ready | input | 1 | Sender can accept a frame |
| snd_start | output | 1 | One-cycle start pulse |
| snd_addr | output | 32 | Buffer address |
| snd_len | output | 12 | Buffer length in bytes |
| snd_last | output | 1 | Buffer ends the frame |
| snd_done | input | 1 | Sender outcome valid |
| snd_ok | input | 1 | Sent without error |
| snd_carrier_lost | input | 1 | Carrier lost |
| snd_late_coll | input | 1 | Late collision |
| snd_underrun | input | 1 | Transmit underrun |
| snd_excess_coll | input | 1 | Too many collisions |
| snd_coll_cnt | input | 5 | Collisions seen |
| sts_wr_en | output | 1 | Status write strobe |
| sts_wr_addr | output | $clog2(DEPTH) | Status ring entry |
| sts_wr_data | output | 32 | Packed status word |
| int_en | input | 1 | Transmit interrupt enable |
| int_clr | input | 1 | Clear raw interrupt flag |
| pending | output | $clog2(DEPTH)+1 | Descriptors still queued |
| int_raw | output | 1 | Raw transmit interrupt flag |
| irq | output | 1 | Masked transmit interrupt |

## Verification
A wrong pointer shows up within a few cycles of the next fetch or status write. It appears as an unexpected entry number on the read or write address, or as a status word whose echoed index does not match the descriptor it stands for. A pending count that is off leaves the queue either stalled with work outstanding or fetching an entry that software never enqueued, and the pending output exposes it on the very next cycle. Errors in packing or abort handling appear in the first status word written for the affected descriptor, and a stray send appears as a start pulse for an aborted descriptor.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int WORD_W  = 32;
  localparam int LEN_W   = 12;
  localparam int BIDX_W  = 15;
  localparam int NCOLL_W = 5;

  // control word fields
  localparam int CW_LAST  = 31;
  localparam int CW_IDX_L = 16;
  localparam int CW_ABORT = 15;

  // status word fields
  localparam int SW_DONE   = 31;
  localparam int SW_OK     = 30;
  localparam int SW_ABORT  = 29;
  localparam int SW_CRS    = 28;
  localparam int SW_LATE   = 26;
  localparam int SW_UNDER  = 25;
  localparam int SW_EXCESS = 24;
  localparam int SW_NCOL_L = 16;

  typedef struct packed {
    logic               ok;
    logic               carrier_lost;
    logic               late_coll;
    logic               underrun;
    logic               excess_coll;
    logic [NCOLL_W-1:0] coll_cnt;
  } send_result_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_DECODE, ST_SEND, ST_WAIT
  } txq_state_t;
endpackage

// File: rtl/txq_ring_ptr.sv
module txq_ring_ptr #(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      always_ff @(posedge clk) begin
        if (rst)      ptr <= '0;
        else if (adv) ptr <= ptr + 1'b1;
      end
    end else begin : g_cmp
      always_ff @(posedge clk) begin
        if (rst)      ptr <= '0;
        else if (adv) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
      end
    end
  endgenerate

  assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (adv && ptr == LAST) |=> (ptr == '0));
  assert_step_R7: assert property (@(posedge clk) disable iff (rst)
    (adv && ptr != LAST) |=> (ptr == $past(ptr) + 1'b1));
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(ptr));
endmodule

// File: rtl/txq_pend_ctr.sv
module txq_pend_ctr #(
  parameter int DEPTH = 8,
  parameter int ENQ_W = 8,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             add_en,
  input  logic [ENQ_W-1:0] add_cnt,
  input  logic             sub,
  output logic [CW-1:0]    count
);
  localparam int SUM_W = CW + ENQ_W + 1;

  logic [SUM_W-1:0] grown;
  logic [CW-1:0]    count_nxt;

  always_comb begin
    grown = SUM_W'(count) + (add_en ? SUM_W'(add_cnt) : '0) - (sub ? SUM_W'(1) : '0);
    count_nxt = (grown > SUM_W'(DEPTH)) ? CW'(DEPTH) : grown[CW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count_nxt;
  end

  assert_pend_bound_R2: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
    sub |-> (count != '0));
endmodule

// File: rtl/txq_status_pack.sv
module txq_status_pack
  import txq_pkg::*;
(
  input  logic              aborted,
  input  logic [BIDX_W-1:0] bidx,
  input  send_result_t      res,
  output logic [WORD_W-1:0] word
);
  always_comb begin
    word = '0;
    word[SW_DONE]  = 1'b1;
    word[SW_ABORT] = aborted;
    word[BIDX_W-1:0] = bidx;
    if (!aborted) begin
      word[SW_OK]     = res.ok;
      word[SW_CRS]    = res.carrier_lost;
      word[SW_LATE]   = res.late_coll;
      word[SW_UNDER]  = res.underrun;
      word[SW_EXCESS] = res.excess_coll;
      word[SW_NCOL_L +: NCOLL_W] = res.coll_cnt;
    end
  end
endmodule

// File: rtl/txq_manager.sv
module txq_manager
  import txq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int ENQ_W = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dma_en,
  input  logic             enq_valid,
  input  logic [ENQ_W-1:0] enq_count,
  output logic             desc_rd_en,
  output logic [AW-1:0]    desc_rd_addr,
  input  logic [31:0]      desc_word0,
  input  logic [31:0]      desc_word1,
  input  logic             snd_ready,
  output logic             snd_start,
  output logic [31:0]      snd_addr,
  output logic [11:0]      snd_len,
  output logic             snd_last,
  input  logic             snd_done,
  input  logic             snd_ok,
  input  logic             snd_carrier_lost,
  input  logic             snd_late_coll,
  input  logic             snd_underrun,
  input  logic             snd_excess_coll,
  input  logic [4:0]       snd_coll_cnt,
  output logic             sts_wr_en,
  output logic [AW-1:0]    sts_wr_addr,
  output logic [31:0]      sts_wr_data,
  input  logic             int_en,
  input  logic             int_clr,
  output logic [CW-1:0]    pending,
  output logic             int_raw,
  output logic             irq
);
  txq_state_t        state;
  logic [AW-1:0]     dptr, sptr;
  logic [BIDX_W-1:0] cur_idx, pack_idx;
  logic              desc_abort;
  logic              fetch_go, sts_go, dptr_adv;
  logic              flag_nxt;
  send_result_t      res;
  logic [WORD_W-1:0] packed_word;

  assign res = '{ok: snd_ok, carrier_lost: snd_carrier_lost, late_coll: snd_late_coll,
                 underrun: snd_underrun, excess_coll: snd_excess_coll, coll_cnt: snd_coll_cnt};

  assign desc_abort = desc_word1[CW_ABORT];
  assign fetch_go   = (state == ST_IDLE) && dma_en && (pending != '0);
  assign dptr_adv   = (state == ST_DECODE);
  assign sts_go     = ((state == ST_DECODE) && desc_abort) || ((state == ST_WAIT) && snd_done);
  assign pack_idx   = (state == ST_DECODE) ? desc_word1[CW_IDX_L +: BIDX_W] : cur_idx;
  assign desc_rd_addr = dptr;

  txq_ring_ptr #(.DEPTH(DEPTH)) u_dptr (.clk(clk), .rst(rst), .adv(dptr_adv), .ptr(dptr));
  txq_ring_ptr #(.DEPTH(DEPTH)) u_sptr (.clk(clk), .rst(rst), .adv(sts_go), .ptr(sptr));

  txq_pend_ctr #(.DEPTH(DEPTH), .ENQ_W(ENQ_W)) u_pend (
    .clk(clk), .rst(rst), .add_en(enq_valid), .add_cnt(enq_count),
    .sub(sts_go), .count(pending));

  txq_status_pack u_pack (
    .aborted(state == ST_DECODE), .bidx(pack_idx), .res(res), .word(packed_word));

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      desc_rd_en  <= 1'b0;
      snd_start   <= 1'b0;
      snd_addr    <= '0;
      snd_len     <= '0;
      snd_last    <= 1'b0;
      cur_idx     <= '0;
      sts_wr_en   <= 1'b0;
      sts_wr_addr <= '0;
      sts_wr_data <= '0;
    end else begin
      desc_rd_en <= 1'b0;
      snd_start  <= 1'b0;
      sts_wr_en  <= 1'b0;
      if (sts_go) begin
        sts_wr_en   <= 1'b1;
        sts_wr_addr <= sptr;
        sts_wr_data <= packed_word;
      end
      case (state)
        ST_IDLE: if (fetch_go) begin
          desc_rd_en <= 1'b1;
          state      <= ST_READ;
        end
        ST_READ: state <= ST_DECODE;
        ST_DECODE: begin
          cur_idx  <= desc_word1[CW_IDX_L +: BIDX_W];
          snd_addr <= desc_word0;
          snd_len  <= desc_word1[LEN_W-1:0];
          snd_last <= desc_word1[CW_LAST];
          state    <= desc_abort ? ST_IDLE : ST_SEND;
        end
        ST_SEND: if (snd_ready) begin
          snd_start <= 1'b1;
          state     <= ST_WAIT;
        end
        ST_WAIT: if (snd_done) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign flag_nxt = sts_go | (int_raw & ~int_clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      int_raw <= 1'b0;
      irq     <= 1'b0;
    end else begin
      int_raw <= flag_nxt;
      irq     <= flag_nxt & int_en;
    end
  end

  assert_fetch_pending_R3: assert property (@(posedge clk) disable iff (rst)
    desc_rd_en |-> (pending != '0) && $past(dma_en));
  assert_start_ready_R10: assert property (@(posedge clk) disable iff (rst)
    snd_start |-> $past(snd_ready));
  assert_done_bit_R5: assert property (@(posedge clk) disable iff (rst)
    sts_wr_en |-> sts_wr_data[SW_DONE]);
  assert_abort_not_ok_R6: assert property (@(posedge clk) disable iff (rst)
    (sts_wr_en && sts_wr_data[SW_ABORT]) |-> !sts_wr_data[SW_OK]);
  assert_irq_enabled_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(int_en));
  assert_one_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    $countones({desc_rd_en, snd_start, sts_wr_en}) <= 1);
endmodule

// File: tb/txq_manager_test.sv
module txq_manager_test;
  localparam int DEPTH = 8;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic dma_en = 1'b0, enq_valid = 1'b0, snd_ready = 1'b1;
  logic [7:0] enq_count = '0;
  logic desc_rd_en, snd_start, snd_last, sts_wr_en, int_raw, irq;
  logic [AW-1:0] desc_rd_addr, sts_wr_addr;
  logic [31:0] desc_word0, desc_word1, snd_addr, sts_wr_data;
  logic [11:0] snd_len;
  logic [3:0] pending;
  logic snd_done = 1'b0;
  logic [9:0] res_drive = '0;
  logic [9:0] res_now = '0;
  logic int_en = 1'b0, int_clr = 1'b0;

  txq_manager uut (
    .clk(clk), .rst(rst), .dma_en(dma_en), .enq_valid(enq_valid), .enq_count(enq_count),
    .desc_rd_en(desc_rd_en), .desc_rd_addr(desc_rd_addr),
    .desc_word0(desc_word0), .desc_word1(desc_word1),
    .snd_ready(snd_ready), .snd_start(snd_start), .snd_addr(snd_addr),
    .snd_len(snd_len), .snd_last(snd_last), .snd_done(snd_done),
    .snd_ok(res_now[9]), .snd_carrier_lost(res_now[8]), .snd_late_coll(res_now[7]),
    .snd_underrun(res_now[6]), .snd_excess_coll(res_now[5]), .snd_coll_cnt(res_now[4:0]),
    .sts_wr_en(sts_wr_en), .sts_wr_addr(sts_wr_addr), .sts_wr_data(sts_wr_data),
    .int_en(int_en), .int_clr(int_clr), .pending(pending), .int_raw(int_raw), .irq(irq));

  // descriptor memory, one-cycle read latency
  logic [31:0] mem0 [DEPTH];
  logic [31:0] mem1 [DEPTH];
  always @(posedge clk) if (desc_rd_en) begin
    desc_word0 <= mem0[desc_rd_addr];
    desc_word1 <= mem1[desc_rd_addr];
  end

  // monitors
  int sts_n = 0, rd_n = 0, snd_n = 0;
  logic [31:0] last_sts, last_saddr;
  logic [AW-1:0] last_sidx;
  logic [11:0] last_slen;
  logic last_slast;
  always @(posedge clk) begin
    if (sts_wr_en) begin sts_n <= sts_n + 1; last_sts <= sts_wr_data; last_sidx <= sts_wr_addr; end
    if (desc_rd_en) rd_n <= rd_n + 1;
    if (snd_start) begin
      snd_n <= snd_n + 1; last_saddr <= snd_addr; last_slen <= snd_len; last_slast <= snd_last;
    end
  end

  // sender model: outcome three cycles after a start pulse
  int scnt = 0;
  always @(negedge clk) begin
    snd_done = 1'b0;
    if (snd_start) scnt = 3;
    else if (scnt > 0) begin
      scnt = scnt - 1;
      if (scnt == 0) begin snd_done = 1'b1; res_now = res_drive; end
    end
  end

  int errors = 0, checks = 0;
  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic enqueue(input int n);
    @(negedge clk); enq_valid = 1'b1; enq_count = 8'(n);
    @(negedge clk); enq_valid = 1'b0; enq_count = '0;
  endtask

  task automatic wait_sts(input int target, input string req);
    int k;
    for (k = 0; k < 400 && sts_n < target; k++) @(negedge clk);
    check(sts_n == target, req, 32'(sts_n), 32'(target));
  endtask

  // {control word, outcome {ok,crs,late,under,excess,ncoll}, expected status}
  localparam logic [73:0] VEC [0:5] = '{
    {32'h8005_0040, 10'b1_0000_00000, 32'hC000_0005},
    {32'h9234_05EA, 10'b1_0000_00011, 32'hC003_1234},
    {32'h7FFF_0FFF, 10'b0_1010_00000, 32'h9200_7FFF},
    {32'h8042_8100, 10'b1_0000_00101, 32'hA000_0042},
    {32'h8007_003C, 10'b0_0101_11111, 32'h851F_0007},
    {32'h8001_0001, 10'b1_0000_00001, 32'hC001_0001}
  };

  initial begin
    #3_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin mem0[i] = 32'hA000_0000 + 32'(i) * 32'h800; mem1[i] = 32'h8000_0010; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(pending == 0, "R1 pending", 32'(pending), 0);
    check(!desc_rd_en && !snd_start && !sts_wr_en, "R1 strobes", {desc_rd_en, snd_start, sts_wr_en}, 0);
    check(!int_raw && !irq, "R1 interrupt", {int_raw, irq}, 0);

    dma_en = 1'b1;
    for (int v = 0; v < 6; v++) begin
      int s0;
      s0 = snd_n;
      mem1[v] = VEC[v][73:42];
      res_drive = VEC[v][41:32];
      enqueue(1);
      wait_sts(v + 1, "R7 one status per descriptor");
      @(negedge clk);
      check(last_sts == VEC[v][31:0], "R5 R6 status word", last_sts, VEC[v][31:0]);
      check(last_sidx == AW'(v), "R7 status slot", 32'(last_sidx), 32'(v));
      if (VEC[v][57]) begin
        check(snd_n == s0, "R6 aborted not sent", 32'(snd_n), 32'(s0));
      end else begin
        check(snd_n == s0 + 1 && last_saddr == mem0[v], "R4 address", last_saddr, mem0[v]);
        check(last_slen == VEC[v][53:42] && last_slast == VEC[v][73], "R4 length/last",
              {last_slast, 19'b0, last_slen}, {VEC[v][73], 19'b0, VEC[v][53:42]});
      end
    end
    check(pending == 0, "R7 pending drained", 32'(pending), 0);

    // R8 raw flag set, masked output off, then enable and clear
    check(int_raw && !irq, "R8 raw set masked", {int_raw, irq}, 32'h2);
    int_en = 1'b1; @(negedge clk);
    check(irq, "R8 irq enabled", 32'(irq), 1);
    int_clr = 1'b1; @(negedge clk); int_clr = 1'b0; @(negedge clk);
    check(!int_raw && !irq, "R8 cleared", {int_raw, irq}, 0);

    // R3 / R7 wrap across entries 6,7,0,1
    res_drive = 10'b1_0000_00000;
    for (int i = 0; i < DEPTH; i++) mem1[i] = 32'h8000_0020 | (32'(i) << 16);
    enqueue(4);
    wait_sts(10, "R3 wrap batch");
    @(negedge clk);
    check(last_sidx == 1 && last_sts == 32'hC000_0001, "R3 R7 wrap to entry 1", last_sts, 32'hC000_0001);
    check(last_saddr == mem0[1], "R3 fetch after wrap", last_saddr, mem0[1]);

    // R9 disabled DMA holds, R2 saturation
    dma_en = 1'b0;
    begin
      int r0;
      r0 = rd_n;
      enqueue(5);
      check(pending == 5, "R2 add count", 32'(pending), 5);
      enqueue(5);
      check(pending == 8, "R2 saturate", 32'(pending), 8);
      repeat (10) @(negedge clk);
      check(rd_n == r0 && pending == 8, "R9 no fetch while disabled", 32'(rd_n - r0), 0);
    end
    dma_en = 1'b1;
    wait_sts(18, "R9 drain after enable");
    @(negedge clk);
    check(pending == 0 && last_sidx == 1, "R9 drained ring", {28'(pending), 1'b0, last_sidx}, 32'h1);

    // R10 sender not ready
    snd_ready = 1'b0;
    begin
      int s0;
      s0 = snd_n;
      enqueue(1);
      repeat (20) @(negedge clk);
      check(snd_n == s0 && sts_n == 18, "R10 held while not ready", 32'(snd_n - s0), 0);
      snd_ready = 1'b1;
      wait_sts(19, "R10 sent once ready");
      check(snd_n == s0 + 1, "R10 one start", 32'(snd_n - s0), 1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule